// File: doc/BRIEF.md
# Dual-Clock Register Bank with Per-Bit Access Control

This block is the storage behind a controller's software-visible registers. Words live in a memory with two sides. A processor side runs on the bus clock and accepts reads and writes. A controller side runs on the internal clock and reads or overwrites any word with no restriction. Status logic posts its updates through the controller side.

Every bit of every word has an access code. The codes sit in a read-only attribute memory whose contents are fixed before operation. A processor write is not stored directly. Its address and data are held on the bus side, and a toggle handshake signals the internal clock domain. There a two-cycle sequence runs: it reads the current word and its attribute codes, then stores the bits merged according to each bit's code. After the store, the bank raises a one-cycle event that carries the written address, so controller logic can react to software activity.

The event path depends only on the bank's own internal reset. A controller that is held in reset can therefore still be woken by it. The processor side reports itself not ready from the moment it accepts a write until the internal domain acknowledges the store.

Top module: `regbank`

## Requirements
- R1: After both resets, `bus_ready` is 1, `evt_valid` is 0, and every word reads as zero from both sides.
- R2: A bit with access code 2'b00 (read/write) takes the value that the processor writes.
- R3: A bit with access code 2'b01 (read-only) keeps its value across processor writes, and the controller side can still set it.
- R4: A bit with access code 2'b10 (write-1-to-clear) becomes 0 where the processor writes 1 and is unchanged where it writes 0.
- R5: A bit with access code 2'b11 (write-1-to-set) becomes 1 where the processor writes 1 and is unchanged where it writes 0.
- R6: The attribute memory gives bit b of word a the access code ((a + b) mod 4), using the encodings listed in R2 to R5.
- R7: A controller-side write (`ip_we`) stores the whole word regardless of access codes. The word is visible on `ip_rdata` one internal clock after `ip_addr` is presented, and on `bus_rdata` one bus clock after a read request.
- R8: Each processor write that is accepted produces exactly one `evt_valid` pulse, one internal clock long, with `evt_addr` equal to the written address.
- R9: `bus_ready` drops in the bus cycle after a write is accepted and stays low until the store is acknowledged. A write offered while it is low changes no word and raises no event.
- R10: While `ip_we` is asserted, a pending processor write is held back. When it is finally stored, the merge uses the value the controller side wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Processor-side clock |
| bus_rst_n | input | 1 | Processor-side asynchronous reset, active low |
| bus_addr | input | AW | Processor word address for reads and writes |
| bus_wr_en | input | 1 | Processor write request, taken when `bus_ready` is 1 |
| bus_wdata | input | DATA_W | Processor write data |
| bus_ready | output | 1 | Processor side can accept a write |
| bus_rd_en | input | 1 | Processor read request |
| bus_rdata | output | DATA_W | Processor read data, one bus clock after the request |
| int_clk | input | 1 | Internal controller clock |
| int_rst_n | input | 1 | Internal asynchronous reset, active low |
| ip_addr | input | AW | Controller-side word address |
| ip_we | input | 1 | Controller-side full-word write |
| ip_wdata | input | DATA_W | Controller-side write data |
| ip_rdata | output | DATA_W | Controller-side read data, one internal clock after the address |
| evt_valid | output | 1 | One-cycle pulse when a processor write has been stored |
| evt_addr | output | AW | Address carried by the write event |

## Verification
The bench uses the default parameters: 32-bit words and 64 words, so the address is 6 bits wide. With these values every word mixes all four access codes, and the code pattern shifts by one bit position from each word to the next. The vectors therefore cover each access behaviour at several bit positions, and they include the last word, 63. The two clocks are unrelated, and this exercises the toggle handshake in both directions. A long controller-side write burst is used to force the held-back store.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [1:0] {
    ACC_RW  = 2'b00,
    ACC_RO  = 2'b01,
    ACC_W1C = 2'b10,
    ACC_W1S = 2'b11
  } acc_e;

  // Access code preloaded for bit b of word a.
  function automatic logic [1:0] code_of(int unsigned a, int unsigned b);
    return 2'((a + b) % 4);
  endfunction

  // Merge of one bit: current value, written value, access code.
  function automatic logic merge_bit(logic [1:0] code, logic cur_b, logic new_b);
    case (acc_e'(code))
      ACC_RW:  return new_b;
      ACC_RO:  return cur_b;
      ACC_W1C: return cur_b & ~new_b;
      default: return cur_b | new_b;
    endcase
  endfunction

endpackage

// File: rtl/regbank_attr_rom.sv
module regbank_attr_rom
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  output logic [2*DATA_W-1:0] attr_q
);

  logic [2*DATA_W-1:0] rom [DEPTH];

  // Fixed contents, computed from the package rule.
  always_comb begin
    for (int w = 0; w < DEPTH; w++)
      for (int b = 0; b < DATA_W; b++)
        rom[w][2*b +: 2] = code_of(w, b);
  end

  always_ff @(posedge clk)
    attr_q <= rom[addr];

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              int_clk,
  input  logic              int_rst_n,
  input  logic              ip_we,
  input  logic [AW-1:0]     ip_addr,
  input  logic [DATA_W-1:0] ip_wdata,
  output logic [DATA_W-1:0] ip_rdata,
  input  logic              cm_we,
  input  logic [AW-1:0]     cm_addr,
  input  logic [DATA_W-1:0] cm_data,
  input  logic [AW-1:0]     rm_addr,
  output logic [DATA_W-1:0] rm_rdata,
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_rd_en,
  input  logic [AW-1:0]     bus_raddr,
  output logic [DATA_W-1:0] bus_rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  // Single write port in the internal domain; the controller side has priority.
  always_ff @(posedge int_clk or negedge int_rst_n) begin
    if (!int_rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (ip_we) begin
      mem_q[ip_addr] <= ip_wdata;
    end else if (cm_we) begin
      mem_q[cm_addr] <= cm_data;
    end
  end

  always_ff @(posedge int_clk or negedge int_rst_n) begin
    if (!int_rst_n) begin
      ip_rdata <= '0;
      rm_rdata <= '0;
    end else begin
      ip_rdata <= mem_q[ip_addr];
      rm_rdata <= mem_q[rm_addr];
    end
  end

  // Processor-side read port.
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n)     bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= mem_q[bus_raddr];
  end

  // R10: a merged store never meets a controller-side write in the same cycle
  a_r10_one_writer: assert property (@(posedge int_clk) disable iff (!int_rst_n)
    !(ip_we && cm_we));

endmodule

// File: rtl/regbank_evt_cdc.sv
module regbank_evt_cdc #(
  parameter int DATA_W = 32,
  parameter int AW     = 6
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_wr_en,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  input  logic              int_clk,
  input  logic              int_rst_n,
  output logic              req_pend,
  output logic [AW-1:0]     hold_addr,
  output logic [DATA_W-1:0] hold_data,
  input  logic              done
);

  logic req_tgl, ack_s1, ack_s2;
  logic req_s1, req_s2, seen_tgl;
  logic accept;

  assign bus_ready = (req_tgl == ack_s2);
  assign accept    = bus_wr_en && bus_ready;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_tgl   <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      ack_s1    <= 1'b0;
      ack_s2    <= 1'b0;
    end else begin
      ack_s1 <= seen_tgl;
      ack_s2 <= ack_s1;
      if (accept) begin
        req_tgl   <= ~req_tgl;
        hold_addr <= bus_addr;
        hold_data <= bus_wdata;
      end
    end
  end

  always_ff @(posedge int_clk or negedge int_rst_n) begin
    if (!int_rst_n) begin
      req_s1   <= 1'b0;
      req_s2   <= 1'b0;
      seen_tgl <= 1'b0;
    end else begin
      req_s1 <= req_tgl;
      req_s2 <= req_s1;
      if (done) seen_tgl <= ~seen_tgl;
    end
  end

  assign req_pend = req_s2 ^ seen_tgl;

  // R9: an accepted write makes the bus side busy in the next cycle
  a_r9_ready_drops: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    accept |=> !bus_ready);

  // R9: held address and data do not move while the bus side is busy
  a_r9_hold_stable: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !bus_ready |=> ($stable(hold_addr) && $stable(hold_data)));

endmodule

// File: rtl/regbank_rmw.sv
module regbank_rmw
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_pend,
  input  logic [AW-1:0]       req_addr,
  input  logic [DATA_W-1:0]   req_data,
  input  logic                ip_we,
  output logic [AW-1:0]       op_addr,
  input  logic [DATA_W-1:0]   old_word,
  input  logic [2*DATA_W-1:0] attr_word,
  output logic                cm_we,
  output logic [DATA_W-1:0]   cm_data,
  output logic                done,
  output logic                evt_valid,
  output logic [AW-1:0]       evt_addr
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_MERGE} st_e;

  st_e               state;
  logic              clash_q;
  logic [DATA_W-1:0] op_data;
  logic              commit;
  logic [DATA_W-1:0] ro_mask;

  assign commit = (state == S_MERGE) && !ip_we && !clash_q;
  assign cm_we  = commit;
  assign done   = commit;

  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      cm_data[b] = merge_bit(attr_word[2*b +: 2], old_word[b], op_data[b]);
      ro_mask[b] = (attr_word[2*b +: 2] == ACC_RO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      clash_q   <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
      evt_valid <= 1'b0;
      evt_addr  <= '0;
    end else begin
      evt_valid <= commit;
      if (commit) evt_addr <= op_addr;
      case (state)
        S_IDLE: if (req_pend) begin
          op_addr <= req_addr;
          op_data <= req_data;
          state   <= S_READ;
        end
        S_READ: begin
          clash_q <= ip_we;
          state   <= S_MERGE;
        end
        default: begin
          clash_q <= 1'b0;
          state   <= (ip_we || clash_q) ? S_READ : S_IDLE;
        end
      endcase
    end
  end

  // R8: one event pulse per stored write, never two cycles long
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);

  // R3: read-only bits leave the merge unchanged
  a_r3_ro_kept: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (((cm_data ^ old_word) & ro_mask) == '0));

endmodule

// File: rtl/regbank.sv
module regbank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              int_clk,
  input  logic              int_rst_n,
  input  logic [AW-1:0]     ip_addr,
  input  logic              ip_we,
  input  logic [DATA_W-1:0] ip_wdata,
  output logic [DATA_W-1:0] ip_rdata,
  output logic              evt_valid,
  output logic [AW-1:0]     evt_addr
);

  logic                req_pend;
  logic [AW-1:0]       hold_addr;
  logic [DATA_W-1:0]   hold_data;
  logic                done;
  logic [AW-1:0]       op_addr;
  logic [DATA_W-1:0]   old_word;
  logic [2*DATA_W-1:0] attr_word;
  logic                cm_we;
  logic [DATA_W-1:0]   cm_data;

  regbank_evt_cdc #(.DATA_W(DATA_W), .AW(AW)) u_cdc (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .int_clk   (int_clk),
    .int_rst_n (int_rst_n),
    .req_pend  (req_pend),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .done      (done)
  );

  regbank_rmw #(.DATA_W(DATA_W), .AW(AW)) u_rmw (
    .clk       (int_clk),
    .rst_n     (int_rst_n),
    .req_pend  (req_pend),
    .req_addr  (hold_addr),
    .req_data  (hold_data),
    .ip_we     (ip_we),
    .op_addr   (op_addr),
    .old_word  (old_word),
    .attr_word (attr_word),
    .cm_we     (cm_we),
    .cm_data   (cm_data),
    .done      (done),
    .evt_valid (evt_valid),
    .evt_addr  (evt_addr)
  );

  regbank_attr_rom #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_attr (
    .clk    (int_clk),
    .addr   (op_addr),
    .attr_q (attr_word)
  );

  regbank_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .int_clk   (int_clk),
    .int_rst_n (int_rst_n),
    .ip_we     (ip_we),
    .ip_addr   (ip_addr),
    .ip_wdata  (ip_wdata),
    .ip_rdata  (ip_rdata),
    .cm_we     (cm_we),
    .cm_addr   (op_addr),
    .cm_data   (cm_data),
    .rm_addr   (op_addr),
    .rm_rdata  (old_word),
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .bus_rd_en (bus_rd_en),
    .bus_raddr (bus_addr),
    .bus_rdata (bus_rdata)
  );

endmodule

// File: tb/regbank_test.sv
module regbank_test;

  localparam int DW = 32;
  localparam int DP = 64;
  localparam int AW = 6;

  logic          bus_clk = 0, int_clk = 0;
  logic          bus_rst_n = 0, int_rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr_en = 0, bus_rd_en = 0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_ready;
  logic [DW-1:0] bus_rdata;
  logic [AW-1:0] ip_addr = '0;
  logic          ip_we = 0;
  logic [DW-1:0] ip_wdata = '0;
  logic [DW-1:0] ip_rdata;
  logic          evt_valid;
  logic [AW-1:0] evt_addr;

  int checks = 0, fails = 0, evt_cnt = 0;
  logic [AW-1:0] last_evt = '0;
  bit finished = 0;

  always #2   bus_clk = ~bus_clk;   // 250 MHz
  always #3.5 int_clk = ~int_clk;

  regbank #(.DATA_W(DW), .DEPTH(DP)) uut (.*);

  always @(negedge int_clk) if (evt_valid) begin
    evt_cnt++;
    last_evt = evt_addr;
  end

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] old;
    logic [DW-1:0] wd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{6'd0,  32'h0000_0000, 32'hFFFF_FFFF},
    '{6'd1,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{6'd2,  32'hFFFF_FFFF, 32'h0000_0000},
    '{6'd9,  32'hA5A5_A5A5, 32'h0F0F_F0F0},
    '{6'd17, 32'h1234_5678, 32'hCAFE_BABE},
    '{6'd42, 32'h0000_FFFF, 32'h00FF_00FF},
    '{6'd62, 32'h8000_0001, 32'h7FFF_FFFE},
    '{6'd63, 32'hDEAD_BEEF, 32'h5555_AAAA}
  };

  // Expected word after a processor write, built from per-code masks.
  function automatic logic [DW-1:0] expect_word(int a, logic [DW-1:0] cur, logic [DW-1:0] wd);
    logic [DW-1:0] m_rw, m_ro, m_clr, m_set;
    m_rw = '0; m_ro = '0; m_clr = '0; m_set = '0;
    for (int b = 0; b < DW; b++) begin
      case ((a + b) & 3)
        0: m_rw[b]  = 1'b1;
        1: m_ro[b]  = 1'b1;
        2: m_clr[b] = 1'b1;
        default: m_set[b] = 1'b1;
      endcase
    end
    return (wd & m_rw) | (cur & m_ro) | (cur & ~wd & m_clr) | ((cur | wd) & m_set);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ip_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge int_clk); ip_we = 1; ip_addr = a; ip_wdata = d;
    @(negedge int_clk); ip_we = 0;
  endtask

  task automatic ip_read(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge int_clk); ip_addr = a;
    @(negedge int_clk); d = ip_rdata;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge bus_clk); bus_addr = a; bus_rd_en = 1;
    @(negedge bus_clk); bus_rd_en = 0; d = bus_rdata;
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge bus_clk);
    while (!bus_ready) @(negedge bus_clk);
    bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk); bus_wr_en = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!bus_ready && n < 500) begin @(negedge bus_clk); n++; end
    if (!bus_ready) check("R9 idle timeout", 0, 1);
    repeat (3) @(negedge int_clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int ec;
    repeat (4) @(negedge int_clk);
    bus_rst_n = 1; int_rst_n = 1;
    repeat (2) @(negedge int_clk);

    // R1 reset state
    check("R1 bus_ready", 32'(bus_ready), 1);
    check("R1 evt_valid", 32'(evt_valid), 0);
    bus_read(6'd5, v);  check("R1 bus word 5", v, 0);
    ip_read(6'd63, v);  check("R1 ip word 63", v, 0);

    // R2-R8 table walk
    for (int i = 0; i < NV; i++) begin
      logic [DW-1:0] exp;
      ip_write(VEC[i].a, VEC[i].old);
      ec = evt_cnt;
      bus_write(VEC[i].a, VEC[i].wd);
      wait_idle();
      exp = expect_word(VEC[i].a, VEC[i].old, VEC[i].wd);
      bus_read(VEC[i].a, v);
      check("R2 R3 R4 R5 R6 merged word", v, exp);
      ip_read(VEC[i].a, v);
      check("R7 ip view of merged word", v, exp);
      check("R8 event count", 32'(evt_cnt - ec), 1);
      check("R8 event addr", 32'(last_evt), 32'(VEC[i].a));
    end

    // R3 and R7: controller side writes all bits, read-only included
    ip_write(6'd11, 32'hFFFF_FFFF);
    ip_read(6'd11, v);  check("R7 ip full word", v, 32'hFFFF_FFFF);
    bus_read(6'd11, v); check("R3 ro bits set by ip", v, 32'hFFFF_FFFF);

    // R9: write offered while busy is ignored
    ip_write(6'd30, 0);
    ip_write(6'd31, 0);
    ec = evt_cnt;
    bus_write(6'd30, 32'hFFFF_FFFF);
    check("R9 ready low after accept", 32'(bus_ready), 0);
    bus_wr_en = 1; bus_addr = 6'd31; bus_wdata = 32'hFFFF_FFFF;
    @(negedge bus_clk); bus_wr_en = 0;
    wait_idle();
    bus_read(6'd31, v); check("R9 ignored write", v, 0);
    bus_read(6'd30, v); check("R9 accepted write", v, expect_word(30, 0, 32'hFFFF_FFFF));
    check("R9 single event", 32'(evt_cnt - ec), 1);
    check("R9 event addr", 32'(last_evt), 30);

    // R10: store held back while ip_we active, merge onto controller value
    ec = evt_cnt;
    @(negedge int_clk); ip_we = 1; ip_addr = 6'd20; ip_wdata = 32'h5A5A_C3C3;
    bus_write(6'd20, 32'hFFFF_0000);
    repeat (30) @(negedge int_clk);
    check("R10 no event during burst", 32'(evt_cnt - ec), 0);
    check("R10 still busy", 32'(bus_ready), 0);
    ip_we = 0;
    wait_idle();
    bus_read(6'd20, v);
    check("R10 merged onto ip value", v, expect_word(20, 32'h5A5A_C3C3, 32'hFFFF_0000));
    check("R10 one event", 32'(evt_cnt - ec), 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule